// File: doc/BRIEF.md
# ADC Self-Calibration Sequencer

This block runs the self-calibration phase of an analog-to-digital converter. Software requests a calibration by writing a one to the calibration bit. The block keeps that bit set and holds the request until the converter has been switched off long enough. It then drives a busy indication toward the converter for a fixed number of converter clock cycles. In the last of those cycles it captures the correction code that the converter presents. The code goes into the ordinary data register through a one-cycle write strobe, and the calibration bit drops in hardware in that same cycle.

While a calibration is pending or running, conversion triggers are held back, so no conversion can disturb the sequence. Once the bit has cleared, triggers pass straight through and normal conversions can resume. Turning the converter back on part-way through a calibration does not cut the sequence short.

Top module: `adc_cal_top`

## Requirements
- R1: While reset is asserted, and right after it, the calibration bit, busy and the data-register write strobe are all 0.
- R2: A one on the set input while idle makes the calibration bit read 1 from the next cycle. It stays 1 until the calibration finishes.
- R3: A pending calibration starts only after the power input has been sampled 0 on OffCycles consecutive clock edges (default 2). Busy rises on the edge after the one that completes this qualification. Any edge that samples the power input at 1 restarts the count.
- R4: Busy stays high for exactly CalCycles clock cycles (default 83).
- R5: In the first cycle after busy falls, the write strobe is 1 for that cycle only, and the calibration bit reads 0. The written data is the code input sampled in the last busy cycle, zero-extended, with code bit 0 in data bit 0.
- R6: The trigger output is forced to 0 while the calibration bit is 1. Otherwise it equals the trigger input.
- R7: Raising the power input while busy does not abort the calibration. Busy still lasts CalCycles cycles and the code is still written.
- R8: A set request while a calibration is pending or running is ignored. It neither lengthens busy nor causes a second write, and the bit clears as usual.
- R9: The write strobe is never 1 outside the end cycle of a calibration, and the data output holds its value between writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Active-low synchronous reset |
| adonIn | input | 1 | Converter power bit, 1 = on |
| calSetIn | input | 1 | Software request to set the calibration bit |
| trigIn | input | 1 | Conversion trigger from the sequencer |
| calCodeIn | input | CodeW | Correction code from the analog converter |
| calBitOut | output | 1 | Calibration bit as software reads it |
| busyOut | output | 1 | Calibration sequence running |
| trigOut | output | 1 | Trigger passed to the converter |
| dataWrEn | output | 1 | Data-register write strobe |
| dataWrData | output | DataW | Value written to the data register |

## Verification
The bench builds the block with CalCycles at 11, OffCycles at 2, an 8-bit code and a 16-bit data register. The short duration lets many complete calibrations fit in a short run. Each run can change the power input while the request is pending, reapply power mid-sequence, or repeat the request while busy. Keeping the power-off count at 2 means the exact start latency checked is the real one, including a power glitch that restarts the count and the case where the converter was already qualified before the request.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

  typedef enum logic [1:0] {
    CAL_IDLE = 2'd0,
    CAL_PEND = 2'd1,
    CAL_RUN  = 2'd2
  } calState_t;

  typedef struct packed {
    logic clearCnt;
    logic stepCnt;
    logic writeCode;
  } calStrobe_t;

endpackage

// File: rtl/adc_cal_ctrl.sv
module adc_cal_ctrl
  import adc_cal_pkg::*;
#(
  parameter int OffCycles = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       adonIn,
  input  logic       calSetIn,
  input  logic       lastStep,
  output calStrobe_t strobe,
  output logic       calBit,
  output logic       busy
);

  localparam int OffW = $clog2(OffCycles + 1);

  calState_t        state, nextState;
  logic [OffW-1:0]  offCnt;
  logic             offOk;

  // power-off qualification: saturating count of edges with power off
  assign offOk = (offCnt == OffW'(OffCycles));

  always_ff @(posedge clk) begin
    if (!rstN)       offCnt <= '0;
    else if (adonIn) offCnt <= '0;
    else if (!offOk) offCnt <= offCnt + 1'b1;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      CAL_IDLE: if (calSetIn) nextState = CAL_PEND;
      CAL_PEND: if (offOk) begin
        strobe.clearCnt = 1'b1;
        nextState       = CAL_RUN;
      end
      CAL_RUN: begin
        strobe.stepCnt = 1'b1;
        if (lastStep) begin
          strobe.writeCode = 1'b1;
          nextState        = CAL_IDLE;
        end
      end
      default: nextState = CAL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= CAL_IDLE;
      calBit <= 1'b0;
    end else begin
      state <= nextState;
      if (state == CAL_IDLE && calSetIn) calBit <= 1'b1;
      else if (strobe.writeCode)         calBit <= 1'b0;
    end
  end

  assign busy = (state == CAL_RUN);

endmodule

// File: rtl/adc_cal_dpath.sv
module adc_cal_dpath
  import adc_cal_pkg::*;
#(
  parameter int CalCycles = 83,
  parameter int CodeW     = 12,
  parameter int DataW     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  calStrobe_t       strobe,
  input  logic [CodeW-1:0] calCodeIn,
  output logic             lastStep,
  output logic             dataWrEn,
  output logic [DataW-1:0] dataWrData
);

  localparam int CntW = (CalCycles > 1) ? $clog2(CalCycles) : 1;
  localparam logic [CntW-1:0] LastCnt = CntW'(CalCycles - 1);

  logic [CntW-1:0] calCnt;

  // duration counter: cleared on entry, advanced every running cycle
  always_ff @(posedge clk) begin
    if (!rstN)                calCnt <= '0;
    else if (strobe.clearCnt) calCnt <= '0;
    else if (strobe.stepCnt)  calCnt <= calCnt + 1'b1;
  end

  assign lastStep = (calCnt == LastCnt);

  // code capture into the data register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataWrEn   <= 1'b0;
      dataWrData <= '0;
    end else begin
      dataWrEn <= strobe.writeCode;
      if (strobe.writeCode) dataWrData <= DataW'(calCodeIn);
    end
  end

endmodule

// File: rtl/adc_cal_top.sv
module adc_cal_top
  import adc_cal_pkg::*;
#(
  parameter int CalCycles = 83,
  parameter int OffCycles = 2,
  parameter int CodeW     = 12,
  parameter int DataW     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             adonIn,
  input  logic             calSetIn,
  input  logic             trigIn,
  input  logic [CodeW-1:0] calCodeIn,
  output logic             calBitOut,
  output logic             busyOut,
  output logic             trigOut,
  output logic             dataWrEn,
  output logic [DataW-1:0] dataWrData
);

  calStrobe_t strobe;
  logic       lastStep;

  adc_cal_ctrl #(.OffCycles(OffCycles)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .adonIn   (adonIn),
    .calSetIn (calSetIn),
    .lastStep (lastStep),
    .strobe   (strobe),
    .calBit   (calBitOut),
    .busy     (busyOut)
  );

  adc_cal_dpath #(.CalCycles(CalCycles), .CodeW(CodeW), .DataW(DataW)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .calCodeIn  (calCodeIn),
    .lastStep   (lastStep),
    .dataWrEn   (dataWrEn),
    .dataWrData (dataWrData)
  );

  // triggers are held back while a calibration is pending or running
  assign trigOut = trigIn & ~calBitOut;

endmodule

// File: rtl/adc_cal_chk.sv
module adc_cal_chk #(
  parameter int CalCycles = 83
) (
  input logic clk,
  input logic rstN,
  input logic adonIn,
  input logic calBitOut,
  input logic busyOut,
  input logic trigOut,
  input logic dataWrEn
);

  logic [31:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)        busyRun <= '0;
    else if (busyOut) busyRun <= busyRun + 1;
    else              busyRun <= '0;
  end

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busyOut && busyRun != 0) |-> (busyRun == 32'(CalCycles)));

  p_start_qual_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyOut) |-> ($past(!adonIn, 2) && $past(!adonIn, 3)));

  p_end_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!busyOut && busyRun != 0) |-> (dataWrEn && !calBitOut));

  p_single_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    dataWrEn |=> !dataWrEn);

  p_trig_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    calBitOut |-> !trigOut);

  p_busy_has_bit_r2: assert property (@(posedge clk) disable iff (!rstN)
    busyOut |-> calBitOut);

endmodule

bind adc_cal_top adc_cal_chk #(.CalCycles(CalCycles)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .adonIn    (adonIn),
  .calBitOut (calBitOut),
  .busyOut   (busyOut),
  .trigOut   (trigOut),
  .dataWrEn  (dataWrEn)
);

// File: tb/sim_adc_cal_top.sv
`timescale 1ns/1ps
module sim_adc_cal_top;

  localparam int CAL = 11;
  localparam int OFF = 2;
  localparam int CW  = 8;
  localparam int DW  = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic          adonIn;
  logic          calSetIn;
  logic          trigIn;
  logic [CW-1:0] calCodeIn;
  logic          calBitOut;
  logic          busyOut;
  logic          trigOut;
  logic          dataWrEn;
  logic [DW-1:0] dataWrData;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adc_cal_top #(.CalCycles(CAL), .OffCycles(OFF), .CodeW(CW), .DataW(DW)) u0 (
    .clk(clk), .rstN(rstN), .adonIn(adonIn), .calSetIn(calSetIn), .trigIn(trigIn),
    .calCodeIn(calCodeIn), .calBitOut(calBitOut), .busyOut(busyOut), .trigOut(trigOut),
    .dataWrEn(dataWrEn), .dataWrData(dataWrData)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expData(logic [CW-1:0] code);
    return 32'(DW'(code));
  endfunction

  function automatic int expLatency(bit preOff);
    return preOff ? 2 : OFF + 1;
  endfunction

  task automatic runCal(int holdHigh, bit preOff, bit glitch, bit adonMid, bit setMid);
    logic [CW-1:0] code;
    int lat;
    int cnt;
    bit earlyWr;
    string tag;
    tag = adonMid ? (setMid ? "R4/R7/R8" : "R4/R7") : (setMid ? "R4/R8" : "R4");
    if (preOff) begin
      adonIn = 1'b0;
      repeat (OFF + 3) tick();
    end else begin
      adonIn = 1'b1;
      tick();
    end
    code = CW'($urandom);
    calCodeIn = code;
    calSetIn = 1'b1;
    tick();
    calSetIn = 1'b0;
    lat = 1;
    check("R2 calBit set", 32'(calBitOut), 1);
    trigIn = 1'b1;
    #0.1;
    check("R6 trigger blocked while pending", 32'(trigOut), 0);
    trigIn = 1'b0;
    if (!preOff) begin
      for (int i = 0; i < holdHigh; i++) begin
        tick();
        check("R3 no start while powered", 32'(busyOut), 0);
      end
      if (glitch) begin
        adonIn = 1'b0;
        tick();
        adonIn = 1'b1;
        tick();
        check("R3 glitch restarts qualification", 32'(busyOut), 0);
      end
      adonIn = 1'b0;
      lat = 0;
    end
    while (!busyOut && lat < 50) begin
      tick();
      lat++;
    end
    check("R3 start latency", 32'(lat), 32'(expLatency(preOff)));
    cnt = 1;
    earlyWr = 1'b0;
    while (busyOut && cnt < 1000) begin
      if (adonMid && cnt == 2) adonIn = 1'b1;
      if (setMid && cnt == 3) calSetIn = 1'b1;
      if (cnt == 4) calSetIn = 1'b0;
      earlyWr |= dataWrEn;
      tick();
      if (busyOut) cnt++;
    end
    calSetIn = 1'b0;
    check({tag, " busy length"}, 32'(cnt), 32'(CAL));
    check("R9 no write while busy", 32'(earlyWr), 0);
    check("R5 write strobe at end", 32'(dataWrEn), 1);
    check("R5 written code", 32'(dataWrData), expData(code));
    check("R5 calBit cleared", 32'(calBitOut), 0);
    trigIn = 1'b1;
    #0.1;
    check("R6 trigger passes when idle", 32'(trigOut), 1);
    trigIn = 1'b0;
    calCodeIn = ~code;
    tick();
    check("R9 strobe one cycle", 32'(dataWrEn), 0);
    check("R9 data holds", 32'(dataWrData), expData(code));
    check("R8 no second start", 32'(busyOut | calBitOut), 0);
    adonIn = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240607));
    rstN = 1'b0;
    adonIn = 1'b1;
    calSetIn = 1'b0;
    trigIn = 1'b0;
    calCodeIn = '0;
    repeat (3) tick();
    check("R1 calBit reset", 32'(calBitOut), 0);
    check("R1 busy reset", 32'(busyOut), 0);
    check("R1 write reset", 32'(dataWrEn), 0);
    rstN = 1'b1;
    tick();
    check("R1 idle after reset", 32'(busyOut | calBitOut | dataWrEn), 0);
    trigIn = 1'b1;
    #0.1;
    check("R6 trigger passes after reset", 32'(trigOut), 1);
    trigIn = 1'b0;

    runCal(2, 1'b0, 1'b0, 1'b0, 1'b0);
    runCal(0, 1'b1, 1'b0, 1'b0, 1'b0);
    runCal(1, 1'b0, 1'b1, 1'b0, 1'b0);
    runCal(0, 1'b0, 1'b0, 1'b1, 1'b1);
    runCal(3, 1'b1, 1'b0, 1'b1, 1'b0);

    for (int n = 0; n < 25; n++) begin
      runCal(int'($urandom_range(0, 4)), 1'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom));
      repeat ($urandom_range(0, 3)) tick();
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule